// File: doc/BRIEF.md
# Binary-Weighted Programmable Delay Line

This block delays a single-bit sample stream by a programmable whole number of clock cycles. The programmable part is a chain of bypass stages, one per bit of the delay code. Stage k either inserts a run of 2^k registers or lets the sample straight through. A fixed pipeline of `LATENCY` cycles sits in series with the chain and is present even when the code is zero. Typical use is deskewing several parallel bit streams: each channel goes through its own instance, and the code is tuned until the channels line up.

The delay code is held in an on-block code register. While the load control is high it follows the code input, one clock later. While the load control is low it keeps its value. Two override controls act directly on this register. Force-minimum clears every bit and force-maximum sets every bit. If both are raised together, force-minimum wins, and both outrank the load control. A blanking control drives the output low without disturbing the samples travelling through the chain.

The stream carries one sample on every clock and cannot stall, so there is no valid/ready handshake and no back-pressure. Every control is active-high, so tying a control low leaves the block in normal operation.

Top module: `bw_delay_line`

## Requirements
- R1: With a steady held code C (bit 0 weighs 1 cycle, bit k weighs 2^k cycles), the output in cycle t equals the input sampled in cycle t - LATENCY - C.
- R2: A held code of 0 gives a delay of exactly LATENCY cycles.
- R3: While `code_load` is high and no override is raised, the held code takes the value of `dly_code` at the next clock edge. While `code_load` is low, changes on `dly_code` have no effect on the delay.
- R4: Raising `force_min` clears the held code to 0 at the next edge. The delay stays LATENCY after `force_min` falls, as long as `code_load` stays low.
- R5: Raising `force_max` alone sets every bit of the held code to 1 at the next edge, giving a delay of LATENCY + 2^NBITS - 1.
- R6: When `force_min` and `force_max` are high together, the held code becomes 0.
- R7: While `blank` is high, `dout` is 0 from the next cycle on. One cycle after `blank` falls, `dout` follows the delayed stream again with no lost history.
- R8: During and right after reset, the held code is 0, every stage holds 0 and `dout` is 0.
- R9: Either override takes precedence over `code_load` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; one sample per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | 1 | Input sample stream |
| dly_code | input | NBITS | Requested delay code, LSB weighs one cycle |
| code_load | input | 1 | High: held code follows `dly_code`; low: hold |
| force_min | input | 1 | Clear held code to all zeros (highest priority) |
| force_max | input | 1 | Set held code to all ones |
| blank | input | 1 | Force `dout` low from the next cycle |
| dout | output | 1 | Delayed sample stream |

## Verification
The bench builds the block with its default parameters: a 10-bit code and a two-cycle fixed latency. These values put every stage weight from 1 to 512 in play, and they make the longest path, 1025 cycles, short enough to flush between test phases. The random codes, together with the all-ones code reached through force-maximum, exercise both the bypass and the insert branch of every stage. The zero code checks the bare fixed latency on its own.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [1:0] {
    OVR_NONE = 2'd0,
    OVR_CLR  = 2'd1,
    OVR_SET  = 2'd2
  } ovr_e;

  // Clear outranks set when both are requested.
  function automatic ovr_e pick_override(input logic clr, input logic set);
    if (clr)      return OVR_CLR;
    else if (set) return OVR_SET;
    else          return OVR_NONE;
  endfunction

endpackage

// File: rtl/pdl_code_hold.sv
module pdl_code_hold #(
  parameter int NBITS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] code_in,
  input  logic             load,
  input  logic             clr,
  input  logic             set,
  output logic [NBITS-1:0] code_q
);
  import pdl_pkg::*;

  ovr_e ovr;

  always_comb ovr = pick_override(clr, set);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
    end else begin
      unique case (ovr)
        OVR_CLR:  code_q <= '0;
        OVR_SET:  code_q <= '1;
        default:  if (load) code_q <= code_in;
      endcase
    end
  end
endmodule

// File: rtl/pdl_fixed_pipe.sv
module pdl_fixed_pipe #(
  parameter int DEPTH = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign q = d;
    end else if (DEPTH == 1) begin : g_one
      logic r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= 1'b0;
        else        r <= d;
      end
      assign q = r;
    end else begin : g_many
      logic [DEPTH-1:0] r;
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= {r[DEPTH-2:0], d};
      end
      assign q = r[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/pdl_tap_stage.sv
module pdl_tap_stage #(
  parameter int WEIGHT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  logic d,
  output logic q
);
  logic late;

  // The run always shifts, so switching it in mid-stream exposes known history.
  pdl_fixed_pipe #(.DEPTH(WEIGHT)) u_run (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (d),
    .q     (late)
  );

  assign q = sel ? late : d;
endmodule

// File: rtl/bw_delay_line.sv
module bw_delay_line #(
  parameter int NBITS   = 10,
  parameter int LATENCY = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [NBITS-1:0] dly_code,
  input  logic             code_load,
  input  logic             force_min,
  input  logic             force_max,
  input  logic             blank,
  output logic             dout
);
  // The output register supplies one cycle of the fixed latency.
  localparam int FRONT = LATENCY - 1;

  logic [NBITS-1:0] held_code;
  logic [NBITS:0]   tap;

  pdl_code_hold #(.NBITS(NBITS)) u_code (
    .clk     (clk),
    .rst_n   (rst_n),
    .code_in (dly_code),
    .load    (code_load),
    .clr     (force_min),
    .set     (force_max),
    .code_q  (held_code)
  );

  pdl_fixed_pipe #(.DEPTH(FRONT)) u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (din),
    .q     (tap[0])
  );

  for (genvar k = 0; k < NBITS; k++) begin : g_stage
    pdl_tap_stage #(.WEIGHT(1 << k)) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .sel   (held_code[k]),
      .d     (tap[k]),
      .q     (tap[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     dout <= 1'b0;
    else if (blank) dout <= 1'b0;
    else            dout <= tap[NBITS];
  end
endmodule

// File: rtl/bw_delay_line_chk.sv
module bw_delay_line_chk #(
  parameter int NBITS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBITS-1:0] dly_code,
  input logic             code_load,
  input logic             force_min,
  input logic             force_max,
  input logic             blank,
  input logic             dout,
  input logic [NBITS-1:0] held_code
);
  assert_min_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    force_min |=> held_code == '0);

  assert_max_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max && !force_min) |=> held_code == '1);

  assert_both_min_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (force_max && force_min) |=> held_code == '0);

  assert_load_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (code_load && !force_min && !force_max) |=> held_code == $past(dly_code));

  assert_hold_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!code_load && !force_min && !force_max) |=> $stable(held_code));

  assert_override_beats_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (code_load && force_min && dly_code != '0) |=> held_code == '0);

  assert_blank_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    blank |=> !dout);

  assert_reset_clear_R8: assert property (@(posedge clk)
    !rst_n |=> (held_code == '0 && !dout));
endmodule

bind bw_delay_line bw_delay_line_chk #(.NBITS(NBITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .dly_code  (dly_code),
  .code_load (code_load),
  .force_min (force_min),
  .force_max (force_max),
  .blank     (blank),
  .dout      (dout),
  .held_code (held_code)
);

// File: tb/bw_delay_line_tb.sv
module bw_delay_line_tb;
  localparam int NBITS   = 10;
  localparam int LATENCY = 2;
  localparam int MAXD    = LATENCY + (1 << NBITS) - 1;
  localparam int FLUSH   = MAXD + 8;
  localparam int WINDOW  = 200;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             din = 1'b0;
  logic [NBITS-1:0] dly_code = '0;
  logic             code_load = 1'b0;
  logic             force_min = 1'b0;
  logic             force_max = 1'b0;
  logic             blank = 1'b0;
  logic             dout;

  int applied = 0;
  int bad = 0;
  int cyc = 0;
  logic hist[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  bw_delay_line #(.NBITS(NBITS), .LATENCY(LATENCY)) u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .din       (din),
    .dly_code  (dly_code),
    .code_load (code_load),
    .force_min (force_min),
    .force_max (force_max),
    .blank     (blank),
    .dout      (dout)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  endtask

  initial begin
    wait (cyc > 150000);
    bad++;
    $display("FAIL watchdog: actual cycle %0d, expected end before 150000", cyc);
    finish_run();
  end

  // Driver pushes each sample into the reference history; monitor compares
  // dout of this cycle against the sample from dly cycles earlier.
  task automatic run(input int n, input bit chk, input int dly,
                     input bit expect_zero, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chk) begin
        logic exp_bit;
        exp_bit = expect_zero ? 1'b0 : hist[hist.size() - dly];
        applied++;
        if (dout !== exp_bit) begin
          bad++;
          $display("FAIL %s: cycle %0d dout actual %b expected %b (delay %0d)",
                   req, cyc, dout, exp_bit, dly);
        end
      end
      din = 1'($urandom_range(0, 1));
      hist.push_back(din);
      if (hist.size() > 4096) void'(hist.pop_front());
    end
  endtask

  task automatic load_code(input logic [NBITS-1:0] c);
    dly_code  = c;
    code_load = 1'b1;
    run(1, 1'b0, 0, 1'b0, "");
    code_load = 1'b0;
    dly_code  = NBITS'($urandom);
  endtask

  task automatic steady(input int dly, input string req);
    run(FLUSH, 1'b0, 0, 1'b0, "");
    run(WINDOW, 1'b1, dly, 1'b0, req);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) hist.push_back(1'b0);
    // R8: reset clears the output
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      applied++;
      if (dout !== 1'b0) begin
        bad++;
        $display("FAIL R8: reset dout actual %b expected 0", dout);
      end
      hist.push_back(1'b0);
    end
    rst_n = 1'b1;
    // R8/R2: held code is zero after reset, so delay is the bare latency
    run(WINDOW, 1'b1, LATENCY, 1'b0, "R8");

    // R2: explicit zero code
    load_code('0);
    steady(LATENCY, "R2");

    // R1: single-bit and random codes
    load_code(NBITS'(1));
    steady(LATENCY + 1, "R1");
    load_code(NBITS'(512));
    steady(LATENCY + 512, "R1");
    for (int j = 0; j < 6; j++) begin
      logic [NBITS-1:0] c;
      c = NBITS'($urandom);
      load_code(c);
      steady(LATENCY + int'(c), "R1");
    end

    // R3: code held while load is low, dly_code changes ignored
    load_code(NBITS'(37));
    dly_code = NBITS'(900);
    run(300, 1'b0, 0, 1'b0, "");
    dly_code = NBITS'(5);
    steady(LATENCY + 37, "R3");

    // R5: force maximum alone
    force_max = 1'b1;
    run(1, 1'b0, 0, 1'b0, "");
    force_max = 1'b0;
    steady(MAXD, "R5");

    // R4: force minimum, then released with load low
    force_min = 1'b1;
    run(1, 1'b0, 0, 1'b0, "");
    force_min = 1'b0;
    steady(LATENCY, "R4");

    // R6: both overrides together, starting from a nonzero code
    load_code(NBITS'(300));
    force_min = 1'b1;
    force_max = 1'b1;
    run(1, 1'b0, 0, 1'b0, "");
    force_min = 1'b0;
    force_max = 1'b0;
    steady(LATENCY, "R6");

    // R9: override beats a simultaneous load
    force_max = 1'b1;
    code_load = 1'b1;
    dly_code  = NBITS'(3);
    run(1, 1'b0, 0, 1'b0, "");
    force_max = 1'b0;
    code_load = 1'b0;
    steady(MAXD, "R9");

    // R7: blanking forces zero, then the stream resumes with history intact
    load_code(NBITS'(20));
    steady(LATENCY + 20, "R7");
    blank = 1'b1;
    run(60, 1'b1, 0, 1'b1, "R7");
    blank = 1'b0;
    run(WINDOW, 1'b1, LATENCY + 20, 1'b0, "R7");

    finish_run();
  end
endmodule